// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors. The local one keeps a shift register of recent outcomes for each branch slot, and that history selects a 2-bit counter. The global one keeps a single shift register of the most recent outcomes of all branches, and that history selects a counter in a second table. A third table of 2-bit counters, the chooser, learns which of the two components has been more accurate in the current context. The chooser then steers a multiplexer that gives the final direction.

The lookup port is combinational. It takes the word-index bits of a branch PC and returns the final prediction, both component predictions and the chooser's selection, all taken from the current table state. The update port takes a resolved branch (the PC index and the actual outcome). On the next clock edge it does four things:

- It trains both component counters.
- It moves the chooser only when exactly one component was right.
- It shifts the outcome into the branch's local history.
- It shifts the outcome into the global history.

History is never updated speculatively.

Top module: `tournament_predictor`

## Requirements
- R1: After synchronous active-low reset, every counter in all three tables holds 1 and every history register holds 0. Until the first update, every lookup therefore returns not-taken from both components and selects the local side.
- R2: Each counter saturates: an increment at 3 keeps 3 and a decrement at 0 keeps 0. A counter reads as taken (or prefers global, for the chooser) when its value is 2 or more.
- R3: The local side works in two steps. The lookup PC index (10 bits by default) selects a 10-bit local history. That history selects one of 1024 local counters, and bit 1 of that counter is `lk_local_taken`.
- R4: The global side uses a 12-bit global history to select one of 4096 global counters. That counter gives `lk_global_taken`.
- R5: By default the chooser table (4096 entries) is indexed by the global history. When the chooser value is 2 or more, `lk_use_global` is 1, and otherwise it is 0. A parameter switches the chooser index to the PC index bits instead.
- R6: `lk_taken` equals `lk_global_taken` when `lk_use_global` is 1, and equals `lk_local_taken` otherwise.
- R7: On every valid update, the local counter and the global counter that the update branch currently maps to both move toward the outcome. This happens whichever side the chooser selects.
- R8: On a valid update, the chooser entry moves by one toward the component that predicted the outcome correctly, and only when exactly one component was correct. When the components agree, the entry is unchanged.
- R9: On a valid update, the outcome shifts into the least significant bit of that branch's local history and of the global history. The oldest bit is dropped.
- R10: When `upd_valid` is 0, no table and no history changes, whatever the values on the other update inputs.
- R11: A lookup and an update in the same cycle do not interact. The lookup reflects the state before the update, and the update is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc_idx | input | 10 | Word-index bits of the branch PC being looked up |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_use_global | output | 1 | Chooser selects the global component |
| lk_local_taken | output | 1 | Local component prediction |
| lk_global_taken | output | 1 | Global component prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc_idx | input | 10 | Word-index bits of the resolved branch PC |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. They also assume that `upd_valid`, `upd_pc_idx` and `upd_taken` are stable around each rising edge, so that the saturation and history-shift properties see a single well-defined write per cycle. The bench drives every input on the falling edge and holds reset for several cycles. It then exercises the block in four ways:
- idle cycles with garbage on the update inputs while `upd_valid` is 0;
- a repeating loop branch;
- a pair of correlated branches;
- random traffic where lookups and updates often hit the same PC index in the same cycle.

// File: rtl/tp_pkg.sv
// Shared types and helpers for the tournament predictor.
// Assumes 2-bit counters throughout; the taken/prefer threshold is the counter MSB.
package tp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_MIN   = 2'd0;

    // Saturating step of a 2-bit counter toward up (1) or down (0).
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        if (up)
            return (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
        else
            return (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
    endfunction
endpackage

// File: rtl/tp_ctr_table.sv
// Table of 2-bit saturating counters with two asynchronous read ports
// (returning only the taken/prefer decision) and one synchronous step port.
// Assumes at most one write per cycle; reads see pre-write contents.
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic             rd_a_hi,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b_hi,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    // Read ports: counter MSB means value 2 or above.
    always_comb begin
        rd_a_hi = mem[rd_a_idx][1];
        rd_b_hi = mem[rd_b_idx][1];
    end

    // Reset every counter to weak-low, else step the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
        end
    end

    // R2: a saturated counter stays saturated when pushed further.
    a_r2_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);
    a_r2_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/tp_hist_table.sv
// Per-slot outcome history shift registers with two asynchronous read ports
// and one shift-in write port. Assumes HIST_W >= 2 and one write per cycle.
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    // Read ports.
    always_comb begin
        rd_a_hist = hist[rd_a_idx];
        rd_b_hist = hist[rd_b_idx];
    end

    // Clear on reset, else shift the outcome into the addressed history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (wr_en) begin
            hist[wr_idx] <= {hist[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

    // R9: the written slot holds the old history moved up by one with the new outcome at bit 0.
    a_r9_local_shift: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist[$past(wr_idx)] == {$past(hist[wr_idx][HIST_W-2:0]), $past(wr_bit)});
endmodule

// File: rtl/tp_ghist.sv
// Global outcome history: one shift register fed by every resolved branch.
// Assumes HIST_W >= 2.
module tp_ghist #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    // Clear on reset, else shift in the resolved outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
    end

    // R9: newest outcome lands at bit 0 and older bits move up.
    a_r9_global_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist == {$past(hist[HIST_W-2:0]), $past(shift_bit)});
    // R10: no shift without a resolved branch.
    a_r10_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/tournament_predictor.sv
// Tournament direction predictor: local two-level and global-history components,
// with a chooser table of 2-bit counters steering the final multiplexer.
// Assumes lookup is combinational on current state and updates are non-speculative.
module tournament_predictor #(
    parameter int PC_IDX_W      = 10,
    parameter int LOCAL_HIST_W  = 10,
    parameter int GLOBAL_HIST_W = 12,
    parameter bit CHOOSE_BY_PC  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PC_IDX_W-1:0] lk_pc_idx,
    output logic                lk_taken,
    output logic                lk_use_global,
    output logic                lk_local_taken,
    output logic                lk_global_taken,
    input  logic                upd_valid,
    input  logic [PC_IDX_W-1:0] upd_pc_idx,
    input  logic                upd_taken
);
    localparam int CHOOSE_IDX_W = CHOOSE_BY_PC ? PC_IDX_W : GLOBAL_HIST_W;

    logic [LOCAL_HIST_W-1:0]  lk_lhist, upd_lhist;
    logic [GLOBAL_HIST_W-1:0] ghist;
    logic [CHOOSE_IDX_W-1:0]  lk_cidx, upd_cidx;
    logic                     upd_local_taken, upd_global_taken, upd_use_global;
    logic                     chooser_wr_en, chooser_wr_up;

    // First level of the local side: per-branch histories.
    tp_hist_table #(.IDX_W(PC_IDX_W), .HIST_W(LOCAL_HIST_W)) u_lhist (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lk_pc_idx),  .rd_a_hist(lk_lhist),
        .rd_b_idx(upd_pc_idx), .rd_b_hist(upd_lhist),
        .wr_en(upd_valid), .wr_idx(upd_pc_idx), .wr_bit(upd_taken)
    );

    // Second level of the local side: counters selected by local history.
    tp_ctr_table #(.IDX_W(LOCAL_HIST_W)) u_lctr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lk_lhist),  .rd_a_hi(lk_local_taken),
        .rd_b_idx(upd_lhist), .rd_b_hi(upd_local_taken),
        .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
    );

    // Global history register.
    tp_ghist #(.HIST_W(GLOBAL_HIST_W)) u_ghist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .shift_bit(upd_taken), .hist(ghist)
    );

    // Global counters selected by global history.
    tp_ctr_table #(.IDX_W(GLOBAL_HIST_W)) u_gctr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ghist), .rd_a_hi(lk_global_taken),
        .rd_b_idx(ghist), .rd_b_hi(upd_global_taken),
        .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
    );

    // Chooser index source picked by parameter.
    generate
        if (CHOOSE_BY_PC) begin : g_choose_pc
            always_comb begin
                lk_cidx  = lk_pc_idx;
                upd_cidx = upd_pc_idx;
            end
        end else begin : g_choose_ghist
            always_comb begin
                lk_cidx  = ghist;
                upd_cidx = ghist;
            end
        end
    endgenerate

    // Chooser trains only on disagreement, toward the component that was right.
    always_comb begin
        chooser_wr_en = upd_valid && (upd_local_taken != upd_global_taken);
        chooser_wr_up = (upd_global_taken == upd_taken);
    end

    tp_ctr_table #(.IDX_W(CHOOSE_IDX_W)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lk_cidx),  .rd_a_hi(lk_use_global),
        .rd_b_idx(upd_cidx), .rd_b_hi(upd_use_global),
        .wr_en(chooser_wr_en), .wr_idx(upd_cidx), .wr_up(chooser_wr_up)
    );

    // Final multiplexer between the two components.
    always_comb lk_taken = lk_use_global ? lk_global_taken : lk_local_taken;

    // R1: first cycle out of reset sees only weak-low counters.
    a_r1_reset_weak: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lk_use_global && !lk_local_taken && !lk_global_taken && !lk_taken));
    // R8: with no valid update, the update-side chooser decision cannot flip when the index is unchanged.
    a_r8_chooser_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && $stable(upd_pc_idx)) |=> $stable(upd_use_global));
endmodule

// File: tb/tournament_predictor_bench.sv
module tournament_predictor_bench;
    localparam int PCW = 10;
    localparam int LHW = 10;
    localparam int GHW = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic [PCW-1:0] lk_pc_idx, upd_pc_idx;
    logic upd_valid, upd_taken;
    logic lk_taken, lk_use_global, lk_local_taken, lk_global_taken;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Reference state.
    int m_lh [1 << PCW];
    int m_lc [1 << LHW];
    int m_gc [1 << GHW];
    int m_cc [1 << GHW];
    int m_gh;

    tournament_predictor u_tournament_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_pc_idx(lk_pc_idx), .lk_taken(lk_taken), .lk_use_global(lk_use_global),
        .lk_local_taken(lk_local_taken), .lk_global_taken(lk_global_taken),
        .upd_valid(upd_valid), .upd_pc_idx(upd_pc_idx), .upd_taken(upd_taken)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    function automatic int sat(input int v, input bit up);
        if (up) return (v >= 3) ? 3 : v + 1;
        return (v <= 0) ? 0 : v - 1;
    endfunction

    task automatic model_reset();
        foreach (m_lh[i]) m_lh[i] = 0;
        foreach (m_lc[i]) m_lc[i] = 1;
        foreach (m_gc[i]) m_gc[i] = 1;
        foreach (m_cc[i]) m_cc[i] = 1;
        m_gh = 0;
    endtask

    // One cycle: drive at falling edge, compare lookup, then advance the model for the next edge.
    task automatic step(input int pc, input bit uv, input int upc, input bit ut, input string tag);
        int l, g, u, lidx;
        @(negedge clk);
        lk_pc_idx = PCW'(pc); upd_valid = uv; upd_pc_idx = PCW'(upc); upd_taken = ut;
        #1;
        l = (m_lc[m_lh[pc]] >= 2);
        g = (m_gc[m_gh] >= 2);
        u = (m_cc[m_gh] >= 2);
        check({"R3 local ", tag}, int'(lk_local_taken), l);
        check({"R4 global ", tag}, int'(lk_global_taken), g);
        check({"R5 chooser ", tag}, int'(lk_use_global), u);
        check({"R6 final ", tag}, int'(lk_taken), u ? g : l);
        if (uv) begin
            lidx = m_lh[upc];
            l = (m_lc[lidx] >= 2);
            g = (m_gc[m_gh] >= 2);
            m_lc[lidx] = sat(m_lc[lidx], ut);
            m_gc[m_gh] = sat(m_gc[m_gh], ut);
            if (l != g) m_cc[m_gh] = sat(m_cc[m_gh], g == int'(ut));
            m_lh[upc] = ((lidx << 1) | int'(ut)) & ((1 << LHW) - 1);
            m_gh = ((m_gh << 1) | int'(ut)) & ((1 << GHW) - 1);
        end
    endtask

    initial begin
        bit prev;
        rst_n = 1'b0; lk_pc_idx = '0; upd_valid = 1'b0; upd_pc_idx = '0; upd_taken = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        check("R1 reset use_global", int'(lk_use_global), 0);
        check("R1 reset taken", int'(lk_taken), 0);
        check("R1 reset local", int'(lk_local_taken), 0);
        check("R1 reset global", int'(lk_global_taken), 0);

        // R10: garbage on update inputs with valid low must leave state untouched.
        for (int i = 0; i < 60; i++) step($urandom % 1024, 1'b0, $urandom % 1024, 1'($urandom), "R10 idle");

        // R2: train one branch taken; histories fill with ones and counters saturate.
        for (int i = 0; i < 16; i++) step(5, 1'b1, 5, 1'b1, "R2 train");
        step(5, 1'b0, 0, 1'b0, "R2 after");
        check("R2 local saturated taken", int'(lk_local_taken), 1);
        check("R2 global saturated taken", int'(lk_global_taken), 1);

        // R7/R8: loop branch (9 taken, 1 not) and a branch correlated with it.
        prev = 1'b0;
        for (int i = 0; i < 400; i++) begin
            bit t = (i % 10) != 9;
            step(3, 1'b1, 3, t, "R7 loop");
            step(7, 1'b1, 7, prev, "R8 correlated");
            prev = t;
        end

        // R9/R11: random traffic, lookups often colliding with same-cycle updates.
        for (int i = 0; i < 3000; i++) begin
            int pc = $urandom % 8;
            int upc = ($urandom % 2) ? pc : ($urandom % 8);
            step(pc, 1'($urandom % 4 != 0), upc, 1'($urandom % 3 != 0), "R9 R11 random");
        end

        // R10 again after learned state.
        for (int i = 0; i < 40; i++) step($urandom % 8, 1'b0, $urandom % 8, 1'($urandom), "R10 hold");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule